// File: doc/BRIEF.md
# Pin Change Interrupt Generator

This block watches a bank of general-purpose pins, split into byte-wide ports, and pulls an active-low interrupt request line whenever a pin configured as an input differs from a stored snapshot of that pin. Every pin passes through a two-flop synchronizer before the comparison. The snapshot holds the last level the host saw on each port. A per-port read strobe from the bus interface refreshes that port's half of the snapshot, so the interrupt clears either when the host reads the port or when the pin returns to its old level by itself.

The direction of each pin comes from the configuration logic. A direction bit of 1 marks an input and a direction bit of 0 marks an output. Pins in output mode are masked from the comparison. If a pin is switched back to input mode while its level differs from the snapshot, the interrupt is raised. After reset the snapshot primes itself from the synchronized pin levels, and the interrupt stays released while it does so.

Top module: `pin_change_irq`

## Requirements
- R1: A rising edge on an input-mode pin drives `irq_n_o` low on the third rising clock edge after the change: two synchronizer flops, then the interrupt register.
- R2: A falling edge on an input-mode pin asserts the interrupt with the same three-edge latency.
- R3: A pin whose direction bit is 0 (output mode) never asserts the interrupt, whatever its level does.
- R4: When every mismatching input pin returns to its snapshot value, `irq_n_o` returns high on the third clock edge after the return.
- R5: `rd_strobe_i[p]` loads the synchronized levels of port p into the snapshot. Bit 0 covers pins 7:0 and bit 1 covers pins 15:8. An interrupt caused only by that port releases at the same clock edge as the strobe.
- R6: A read strobe for the other port leaves a pending interrupt asserted.
- R7: A pin change that happens after a read clear is detected and signalled again.
- R8: Switching a pin from output to input asserts the interrupt at the next clock edge if the pin's synchronized level differs from its snapshot.
- R9: During and after reset `irq_n_o` is high. The snapshot primes from the current pin levels, so steady pins with any pattern cause no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 16 | Raw pin levels, asynchronous to clk |
| dir_in_i | input | 16 | Per-pin direction, 1 = input, 0 = output |
| rd_strobe_i | input | 2 | One-cycle read pulse per port (bit p = port p) |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
A non-zero pin pattern is held across reset to show that priming removes any false interrupt. Single-pin rises and falls on an input, with a check one edge early and one edge on time, confirm the latency and cover both edge directions. A pin that toggles and then returns separates a self-clear from a read clear. A strobe on the wrong port and then on the right port shows that the clear is per port. Toggling an output-mode pin and then flipping its direction separates masking from the mismatch check that applies on the switch back to input.

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int NUM_PORTS   = 2,
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_i,
  input  logic [NUM_PORTS*PORT_W-1:0]   dir_in_i,
  input  logic [NUM_PORTS-1:0]          rd_strobe_i,
  output logic                          irq_n_o
);
  localparam int WIDTH = NUM_PORTS * PORT_W;
  localparam int CW    = $clog2(SYNC_STAGES + 1);

  logic [SYNC_STAGES-1:0][WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] pin_s, snap_q, rd_mask, change;
  logic [CW-1:0]    prime_cnt;
  logic             primed, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end
  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_cnt <= '0;
      primed    <= 1'b0;
    end else if (!primed) begin
      prime_cnt <= prime_cnt + 1'b1;
      if (prime_cnt == CW'(SYNC_STAGES)) primed <= 1'b1;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign rd_mask[p*PORT_W +: PORT_W] = {PORT_W{rd_strobe_i[p]}};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        snap_q[p*PORT_W +: PORT_W] <= '0;
      else if (!primed || rd_strobe_i[p])
        snap_q[p*PORT_W +: PORT_W] <= pin_s[p*PORT_W +: PORT_W];
    end
  end

  assign change = (pin_s ^ snap_q) & dir_in_i & ~rd_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= primed & (|change);
  end

  assign irq_n_o = ~irq_q;
endmodule

module pin_change_irq_chk #(
  parameter int NUM_PORTS = 2,
  parameter int WIDTH     = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [WIDTH-1:0]     dir_in_i,
  input logic [NUM_PORTS-1:0] rd_strobe_i,
  input logic                 irq_n_o,
  input logic                 primed
);
  a_r9_idle_until_primed: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> primed);

  a_r3_outputs_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in_i == '0) |=> irq_n_o);

  a_r5_full_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (&rd_strobe_i) |=> irq_n_o);

  a_r5_no_assert_on_full_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_o) |-> !(&$past(rd_strobe_i)));

  a_r3_needs_input_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_o) |-> (|$past(dir_in_i)));
endmodule

bind pin_change_irq pin_change_irq_chk #(.NUM_PORTS(NUM_PORTS), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_in_i(dir_in_i), .rd_strobe_i(rd_strobe_i),
  .irq_n_o(irq_n_o), .primed(primed)
);

// File: tb/test_pin_change_irq.sv
module test_pin_change_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin = 16'hA55A;
  logic [15:0] dir = 16'hFFFF;
  logic [1:0]  rd = 2'b00;
  logic        irq_n;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  pin_change_irq i_pin_change_irq (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .dir_in_i(dir),
    .rd_strobe_i(rd), .irq_n_o(irq_n)
  );

  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irq_n=%b expected %b", req, act, exp);
    end
  endtask

  task automatic read_port(input int p);
    rd[p] = 1'b1;
    tick(1);
    rd = 2'b00;
  endtask

  task automatic t_reset();
    check("R9 in reset", irq_n, 1'b1);
    rst_n = 1'b1;
    tick(6);
    check("R9 primed no irq", irq_n, 1'b1);
  endtask

  task automatic t_rise_and_return();
    pin[0] = 1'b1;
    tick(2);
    check("R1 not before third edge", irq_n, 1'b1);
    tick(1);
    check("R1 rising asserts", irq_n, 1'b0);
    pin[0] = 1'b0;
    tick(2);
    check("R4 still held", irq_n, 1'b0);
    tick(1);
    check("R4 return releases", irq_n, 1'b1);
  endtask

  task automatic t_fall_and_read();
    pin[1] = 1'b0;
    tick(3);
    check("R2 falling asserts", irq_n, 1'b0);
    read_port(1);
    check("R6 other port read keeps irq", irq_n, 1'b0);
    read_port(0);
    check("R5 port read clears", irq_n, 1'b1);
    tick(3);
    check("R5 stays clear", irq_n, 1'b1);
    pin[1] = 1'b1;
    tick(3);
    check("R7 change after clear", irq_n, 1'b0);
    read_port(0);
    check("R5 second clear", irq_n, 1'b1);
  endtask

  task automatic t_output_mask();
    dir[15] = 1'b0;
    tick(1);
    pin[15] = 1'b0;
    tick(3);
    check("R3 output pin masked", irq_n, 1'b1);
    pin[15] = 1'b1;
    tick(3);
    pin[15] = 1'b0;
    tick(4);
    check("R3 output toggles masked", irq_n, 1'b1);
    dir[15] = 1'b1;
    tick(1);
    check("R8 switch to input asserts", irq_n, 1'b0);
    read_port(1);
    check("R5 upper port read clears", irq_n, 1'b1);
  endtask

  initial begin
    tick(3);
    t_reset();
    t_rise_and_return();
    t_fall_and_read();
    t_output_mask();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run hung");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule